// File: doc/BRIEF.md
# Single-Wire SPI Memory Transaction Engine

This block runs one whole SPI flash transaction at a time. The transaction uses a single data line in each direction and the bytes come from one 128-byte scratch buffer that is reached over a simple register bus. Software first writes into the front of the buffer the opcode, the address bytes, any dummy bytes and any write payload. It then programs how many bytes to send and how many to receive. A single control write starts the engine. Chip select goes low and the engine shifts the send bytes out most-significant bit first, in clock-idle-low, sample-on-rising mode. After that it clocks in the requested number of bytes. Each received byte is written into the same buffer directly behind the last byte that was sent.

Software polls the control word. A ready flag rises when a transaction is accepted. A work-in-progress flag stays high until chip select has gone back high and the programmed deselect time has run out. A self-clearing software reset in the misc register aborts any transfer and forces the state field to idle. The serial clock is the system clock divided by two. Every serial bit takes one system cycle with the clock low and one with the clock high.

Register map (byte offsets, 32-bit words): control 0x00, send count 0x04, receive count 0x08, misc 0x0C, status 0x10, buffer 0x80 to 0xFF.

Top module: `spi_mem_xfer_engine`

## Requirements
- R1: The buffer is read and written as 32-bit words at 0x80 + 4*w. Buffer byte 4*w+k sits in data bits [8k+7:8k], so each word is little-endian.
- R2: In the control word, bit 0 is the work-in-progress flag, bit 1 is ready, bit 2 is the trigger (it reads back as 0), bit 3 is enable and bit 4 is an extended-I/O select that is only stored. A control write with bits 3 and 2 both set, while the engine is idle and the counts are legal, does three things at the next edge: it drives chip select low and sets both ready and work-in-progress. A later control write with bit 3 clear, made while the engine is idle, clears ready.
- R3: A trigger written while work-in-progress is set is ignored. No extra bytes are clocked.
- R4: A trigger is ignored when the send count (bits 7:0 at 0x04) plus the receive count (bits 7:0 at 0x08) is 0 or more than 128. A sum of exactly 128 is accepted.
- R5: The serial clock idles low. MOSI changes only while the clock is low. MOSI carries buffer bytes 0 to N-1 (N is the send count) most-significant bit first, and then carries zeros while bytes are being received.
- R6: MISO is sampled on each rising clock edge, most-significant bit first. Received byte k is stored at buffer offset N+k. Bytes below N are left unchanged.
- R7: A transaction produces exactly 8*(send+receive) clock pulses. A transaction with receive count 0 ends after the send phase and leaves the buffer unchanged.
- R8: Between transactions, chip select stays high for at least the deselect count (misc bits 4:0) in system cycles. Work-in-progress stays set until that interval has ended.
- R9: Writing 1 to misc bit 28 has these effects at the next edge: it aborts any transfer, raises chip select, clears work-in-progress and ready, and sets status bits 3:0 to 0 (idle). Bit 28 always reads back 0.
- R10: The misc register stores a read-latency field in bits 26:25, a latch-latency field in bits 9:8 and the deselect count in bits 4:0. After reset the misc register reads 2 in the read-latency field and 10 in the deselect count.
- R11: While work-in-progress is set, bus writes to the buffer and to both count registers are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register bus write strobe |
| regAddr | input | 8 | Register bus byte address |
| regWdata | input | 32 | Register bus write data |
| regRdata | output | 32 | Register bus read data (combinational) |
| spiSck | output | 1 | Serial clock, idles low |
| spiCsN | output | 1 | Chip select, active low |
| spiMosi | output | 1 | Serial data to the memory |
| spiMiso | input | 1 | Serial data from the memory |

## Verification
The assertions are checked on every cycle. They check that the clock stays low while chip select is high, and that MOSI holds steady across each rising clock edge. They also check that chip select is low only while work-in-progress is set, that work-in-progress implies ready, that chip select stays high for the deselect time before every falling edge, and that a software reset leaves the pins and state idle one cycle later. Some behaviour can only be shown by the bench's scenarios: the byte order on MOSI, where received bytes land in the buffer, ignored triggers and writes, the boundary at 128 bytes, and the exact clock-pulse totals. The bench shows these with a slave model and a byte scoreboard.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic start;     // load first send byte
    logic sample;    // capture MISO on rising SCK
    logic shift;     // advance send shifter on falling SCK
    logic byteDone;  // end of byte: store received byte, load next
  } xferStrobe_t;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_SHIFT = 4'd1,
    ST_GUARD = 4'd2
  } xferState_e;

  // register word indices (byte offset / 4)
  localparam logic [4:0] REG_CTRL   = 5'd0;
  localparam logic [4:0] REG_OUTCNT = 5'd1;
  localparam logic [4:0] REG_INCNT  = 5'd2;
  localparam logic [4:0] REG_MISC   = 5'd3;
  localparam logic [4:0] REG_STATUS = 5'd4;

  // control bit positions (decoded by software)
  localparam int CTRL_WIP   = 0;
  localparam int CTRL_READY = 1;
  localparam int CTRL_TRIG  = 2;
  localparam int CTRL_EN    = 3;
  localparam int CTRL_XIO   = 4;

  localparam int MISC_SWRST = 28;

endpackage

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
  import spi_xfer_pkg::*;
#(
  parameter int BUF_BYTES = 128,
  parameter int DESEL_W   = 5,
  localparam int CNT_W    = $clog2(BUF_BYTES) + 1,
  localparam int PTR_W    = $clog2(BUF_BYTES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trigReq,
  input  logic               idleReq,
  input  logic               swRstReq,
  input  logic [CNT_W-1:0]   outCnt,
  input  logic [CNT_W-1:0]   inCnt,
  input  logic [DESEL_W-1:0] deselCnt,
  output xferStrobe_t        strobe,
  output logic [PTR_W-1:0]   bytePtr,
  output logic               wipFlag,
  output logic               readyFlag,
  output logic [3:0]         stateCode,
  output logic               spiSck,
  output logic               spiCsN
);

  xferState_e           state;
  logic [2:0]           bitCnt;
  logic [DESEL_W-1:0]   guardCnt;
  logic [CNT_W:0]       totalBytes;
  logic [CNT_W:0]       ptrNext;
  logic                 trigOk;
  logic                 lastByte;
  logic                 guardDone;

  assign totalBytes = {1'b0, outCnt} + {1'b0, inCnt};
  assign ptrNext    = {{(CNT_W + 1 - PTR_W){1'b0}}, bytePtr} + 1'b1;
  assign lastByte   = (ptrNext == totalBytes);
  assign trigOk     = trigReq && !wipFlag && (totalBytes != '0) &&
                      (totalBytes <= (CNT_W + 1)'(BUF_BYTES));
  assign guardDone  = (deselCnt == '0) ||
                      (({1'b0, guardCnt} + 1'b1) >= {1'b0, deselCnt});
  assign stateCode  = state;

  always_comb begin
    strobe = '0;
    unique case (state)
      ST_IDLE:  strobe.start = trigOk;
      ST_SHIFT: begin
        if (!spiSck)            strobe.sample   = 1'b1;
        else if (bitCnt == 3'd7) strobe.byteDone = 1'b1;
        else                    strobe.shift    = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      bytePtr   <= '0;
      guardCnt  <= '0;
      wipFlag   <= 1'b0;
      readyFlag <= 1'b0;
      spiSck    <= 1'b0;
      spiCsN    <= 1'b1;
    end else if (swRstReq) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      bytePtr   <= '0;
      guardCnt  <= '0;
      wipFlag   <= 1'b0;
      readyFlag <= 1'b0;
      spiSck    <= 1'b0;
      spiCsN    <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (trigOk) begin
            state     <= ST_SHIFT;
            bitCnt    <= '0;
            bytePtr   <= '0;
            wipFlag   <= 1'b1;
            readyFlag <= 1'b1;
            spiCsN    <= 1'b0;
            spiSck    <= 1'b0;
          end else if (idleReq) begin
            readyFlag <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (!spiSck) begin
            spiSck <= 1'b1;
          end else begin
            spiSck <= 1'b0;
            if (bitCnt == 3'd7) begin
              bitCnt <= '0;
              if (lastByte) begin
                state    <= ST_GUARD;
                spiCsN   <= 1'b1;
                guardCnt <= '0;
              end else begin
                bytePtr <= bytePtr + 1'b1;
              end
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        ST_GUARD: begin
          guardCnt <= guardCnt + 1'b1;
          if (guardDone) begin
            state   <= ST_IDLE;
            wipFlag <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_xfer_datapath.sv
module spi_xfer_datapath
  import spi_xfer_pkg::*;
#(
  parameter int BUF_BYTES = 128,
  parameter int DESEL_W   = 5,
  parameter int DESEL_RST = 10,
  parameter int RDLAT_RST = 2,
  localparam int ADDR_W   = $clog2(BUF_BYTES) + 1,
  localparam int CNT_W    = $clog2(BUF_BYTES) + 1,
  localparam int PTR_W    = $clog2(BUF_BYTES),
  localparam int WORDS    = BUF_BYTES / 4,
  localparam int WORD_W   = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [31:0]        regWdata,
  output logic [31:0]        regRdata,
  input  xferStrobe_t        strobe,
  input  logic [PTR_W-1:0]   bytePtr,
  input  logic               wipFlag,
  input  logic               readyFlag,
  input  logic [3:0]         stateCode,
  input  logic               spiMiso,
  output logic               spiMosi,
  output logic [CNT_W-1:0]   outCnt,
  output logic [CNT_W-1:0]   inCnt,
  output logic [DESEL_W-1:0] deselCnt,
  output logic               trigReq,
  output logic               idleReq,
  output logic               swRstReq
);

  logic [7:0]        bufMem [BUF_BYTES];
  logic [7:0]        txShift;
  logic [7:0]        rxShift;
  logic              ctrlEn;
  logic              ctrlXio;
  logic [1:0]        rdLat;
  logic [1:0]        latchLat;

  logic              isBuf;
  logic              isAligned;
  logic [WORD_W-1:0] wordSel;
  logic [ADDR_W-4:0] regIdx;
  logic              regHit;
  logic [CNT_W-1:0]  ptrWide;
  logic [CNT_W-1:0]  nextWide;
  logic [7:0]        nextTx;
  logic              storeRx;

  assign isBuf     = regAddr[ADDR_W-1];
  assign isAligned = (regAddr[1:0] == 2'b00);
  assign wordSel   = regAddr[2 +: WORD_W];
  assign regIdx    = regAddr[ADDR_W-2:2];
  assign regHit    = regWrEn && !isBuf && isAligned;

  assign trigReq  = regHit && (regIdx == (ADDR_W-3)'(REG_CTRL)) &&
                    regWdata[CTRL_EN] && regWdata[CTRL_TRIG];
  assign idleReq  = regHit && (regIdx == (ADDR_W-3)'(REG_CTRL)) && !regWdata[CTRL_EN];
  assign swRstReq = regHit && (regIdx == (ADDR_W-3)'(REG_MISC)) && regWdata[MISC_SWRST];

  assign ptrWide  = {1'b0, bytePtr};
  assign nextWide = ptrWide + 1'b1;
  assign nextTx   = (nextWide < outCnt) ? bufMem[nextWide[PTR_W-1:0]] : 8'h00;
  assign storeRx  = (ptrWide >= outCnt);
  assign spiMosi  = txShift[7];

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn   <= 1'b0;
      ctrlXio  <= 1'b0;
      outCnt   <= '0;
      inCnt    <= '0;
      rdLat    <= 2'(RDLAT_RST);
      latchLat <= '0;
      deselCnt <= DESEL_W'(DESEL_RST);
    end else if (regHit) begin
      unique case (regIdx)
        (ADDR_W-3)'(REG_CTRL): begin
          ctrlEn  <= regWdata[CTRL_EN];
          ctrlXio <= regWdata[CTRL_XIO];
        end
        (ADDR_W-3)'(REG_OUTCNT): if (!wipFlag) outCnt <= regWdata[CNT_W-1:0];
        (ADDR_W-3)'(REG_INCNT):  if (!wipFlag) inCnt  <= regWdata[CNT_W-1:0];
        (ADDR_W-3)'(REG_MISC): begin
          rdLat    <= regWdata[26:25];
          latchLat <= regWdata[9:8];
          deselCnt <= regWdata[DESEL_W-1:0];
        end
        default: ;
      endcase
    end
  end

  // buffer: bus port while idle, engine port while busy
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BUF_BYTES; i++) bufMem[i] <= 8'h00;
    end else begin
      if (regWrEn && isBuf && !wipFlag) begin
        for (int b = 0; b < 4; b++) begin
          bufMem[{wordSel, 2'(b)}] <= regWdata[8*b +: 8];
        end
      end
      if (strobe.byteDone && storeRx) begin
        bufMem[bytePtr] <= rxShift;
      end
    end
  end

  // serial shifters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (strobe.start)         txShift <= (outCnt != '0) ? bufMem[0] : 8'h00;
      else if (strobe.byteDone) txShift <= nextTx;
      else if (strobe.shift)    txShift <= {txShift[6:0], 1'b0};
      if (strobe.sample)        rxShift <= {rxShift[6:0], spiMiso};
    end
  end

  // read mux
  always_comb begin
    regRdata = '0;
    if (isBuf) begin
      for (int b = 0; b < 4; b++) begin
        regRdata[8*b +: 8] = bufMem[{wordSel, 2'(b)}];
      end
    end else if (isAligned) begin
      unique case (regIdx)
        (ADDR_W-3)'(REG_CTRL): begin
          regRdata[CTRL_WIP]   = wipFlag;
          regRdata[CTRL_READY] = readyFlag;
          regRdata[CTRL_EN]    = ctrlEn;
          regRdata[CTRL_XIO]   = ctrlXio;
        end
        (ADDR_W-3)'(REG_OUTCNT): regRdata[CNT_W-1:0] = outCnt;
        (ADDR_W-3)'(REG_INCNT):  regRdata[CNT_W-1:0] = inCnt;
        (ADDR_W-3)'(REG_MISC): begin
          regRdata[26:25]        = rdLat;
          regRdata[9:8]          = latchLat;
          regRdata[DESEL_W-1:0]  = deselCnt;
        end
        (ADDR_W-3)'(REG_STATUS): regRdata[3:0] = stateCode;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/spi_mem_xfer_engine.sv
module spi_mem_xfer_engine
  import spi_xfer_pkg::*;
#(
  parameter int BUF_BYTES = 128,
  parameter int DESEL_W   = 5,
  localparam int ADDR_W   = $clog2(BUF_BYTES) + 1,
  localparam int CNT_W    = $clog2(BUF_BYTES) + 1,
  localparam int PTR_W    = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              spiSck,
  output logic              spiCsN,
  output logic              spiMosi,
  input  logic              spiMiso
);

  xferStrobe_t        strobe;
  logic [PTR_W-1:0]   bytePtr;
  logic               wipFlag;
  logic               readyFlag;
  logic [3:0]         stateCode;
  logic [CNT_W-1:0]   outCnt;
  logic [CNT_W-1:0]   inCnt;
  logic [DESEL_W-1:0] deselCnt;
  logic               trigReq;
  logic               idleReq;
  logic               swRstReq;

  spi_xfer_ctrl #(.BUF_BYTES(BUF_BYTES), .DESEL_W(DESEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .trigReq(trigReq), .idleReq(idleReq), .swRstReq(swRstReq),
    .outCnt(outCnt), .inCnt(inCnt), .deselCnt(deselCnt),
    .strobe(strobe), .bytePtr(bytePtr),
    .wipFlag(wipFlag), .readyFlag(readyFlag), .stateCode(stateCode),
    .spiSck(spiSck), .spiCsN(spiCsN)
  );

  spi_xfer_datapath #(.BUF_BYTES(BUF_BYTES), .DESEL_W(DESEL_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .strobe(strobe), .bytePtr(bytePtr),
    .wipFlag(wipFlag), .readyFlag(readyFlag), .stateCode(stateCode),
    .spiMiso(spiMiso), .spiMosi(spiMosi),
    .outCnt(outCnt), .inCnt(inCnt), .deselCnt(deselCnt),
    .trigReq(trigReq), .idleReq(idleReq), .swRstReq(swRstReq)
  );

endmodule

// File: rtl/spi_xfer_checker.sv
module spi_xfer_checker #(
  parameter int ADDR_W  = 8,
  parameter int DESEL_W = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [31:0]        regWdata,
  input logic               spiSck,
  input logic               spiCsN,
  input logic               spiMosi,
  input logic               wip,
  input logic               ready,
  input logic [3:0]         stateCode,
  input logic [DESEL_W-1:0] deselCnt
);

  localparam logic [6:0] HIGH_MAX = 7'h7F;

  logic       swRstWr;
  logic [6:0] csHighCnt;

  assign swRstWr = regWrEn && (regAddr == ADDR_W'(12)) && regWdata[28];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    csHighCnt <= HIGH_MAX;
    else if (swRstWr)             csHighCnt <= HIGH_MAX;
    else if (!spiCsN)             csHighCnt <= '0;
    else if (csHighCnt != HIGH_MAX) csHighCnt <= csHighCnt + 1'b1;
  end

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSck);                                             // R5

  AST_MOSI_STABLE_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (spiSck && !spiCsN) |-> $stable(spiMosi));                       // R5

  AST_CS_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !spiCsN |-> wip);                                                // R2

  AST_BUSY_IMPLIES_READY: assert property (@(posedge clk) disable iff (!rstN)
    wip |-> ready);                                                  // R2

  AST_DESELECT_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(spiCsN) |-> (csHighCnt >= 7'(deselCnt)));                  // R8

  AST_SWRST_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    swRstWr |=> (spiCsN && !spiSck && !wip && !ready && stateCode == 4'd0)); // R9

endmodule

bind spi_mem_xfer_engine spi_xfer_checker #(.ADDR_W(ADDR_W), .DESEL_W(DESEL_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWdata(regWdata),
  .spiSck(spiSck), .spiCsN(spiCsN), .spiMosi(spiMosi),
  .wip(wipFlag), .ready(readyFlag), .stateCode(stateCode), .deselCnt(deselCnt)
);

// File: tb/tb_spi_mem_xfer_engine.sv
`timescale 1ns/1ps
module tb_spi_mem_xfer_engine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        spiSck, spiCsN, spiMosi;
  logic        spiMiso = 1'b0;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [7:0] img [128];
  logic [7:0] expMosi [$];
  logic [7:0] slvRx = '0;
  logic [7:0] expByte;
  int slvBits = 0;
  int sckRises = 0;

  localparam logic [7:0] A_CTRL = 8'h00, A_OUT = 8'h04, A_IN = 8'h08,
                         A_MISC = 8'h0C, A_STAT = 8'h10, A_BUF = 8'h80;

  always #2.5 clk = ~clk;

  spi_mem_xfer_engine dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata),
    .spiSck(spiSck), .spiCsN(spiCsN), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  function automatic logic [7:0] resp(int i);
    return 8'(i * 29) ^ 8'hC3;
  endfunction

  function automatic logic respBit(int n);
    logic [7:0] r;
    r = resp(n / 8);
    return r[7 - (n % 8)];
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // slave model and monitor: pops expected MOSI bytes as they arrive
  always @(negedge spiCsN) begin
    slvBits = 0;
    spiMiso = respBit(0);
  end
  always @(negedge spiSck) if (!spiCsN) spiMiso = respBit(slvBits);
  always @(posedge spiSck) begin
    slvRx = {slvRx[6:0], spiMosi};
    slvBits++;
    sckRises++;
    if (slvBits % 8 == 0) begin
      if (expMosi.size() == 0) check(0, "R5 unexpected MOSI byte", slvRx, 0);
      else begin
        expByte = expMosi.pop_front();
        check(slvRx == expByte, "R5 MOSI byte", slvRx, expByte);
      end
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic loadWord(int w, logic [31:0] d);
    wr(A_BUF + 8'(4 * w), d);
    for (int b = 0; b < 4; b++) img[4*w+b] = d[8*b +: 8];
  endtask

  // driver: pushes expected MOSI stream, then starts the engine
  task automatic startXfer(int nOut, int nIn);
    for (int i = 0; i < nOut; i++) expMosi.push_back(img[i]);
    for (int i = 0; i < nIn; i++) expMosi.push_back(8'h00);
    sckRises = 0;
    wr(A_CTRL, 32'h08);
    wr(A_OUT, 32'(nOut));
    wr(A_IN, 32'(nIn));
    wr(A_CTRL, 32'h0C);
  endtask

  task automatic waitIdle();
    logic [31:0] d;
    for (int i = 0; i < 20000; i++) begin
      rd(A_CTRL, d);
      if (!d[0]) return;
    end
    check(0, "R2 wip never cleared", 1, 0);
  endtask

  task automatic finish();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R2 watchdog expired actual=%h expected=%h", 0, 1);
      finish();
    end
  end

  initial begin
    logic [31:0] d;
    int lows;
    for (int i = 0; i < 128; i++) img[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state
    rd(A_CTRL, d);  check(d == 0, "R2 ctrl after reset", d, 0);
    rd(A_STAT, d);  check(d == 0, "R9 status idle after reset", d, 0);
    rd(A_MISC, d);  check(d == ((2 << 25) | 10), "R10 misc reset value", d, (2 << 25) | 10);
    check(spiCsN && !spiSck, "R5 pins idle after reset", {spiCsN, spiSck}, 2'b10);

    // misc field storage
    wr(A_MISC, (1 << 25) | (3 << 8) | 7);
    rd(A_MISC, d);  check(d == ((1 << 25) | (3 << 8) | 7), "R10 misc fields", d, (1 << 25) | (3 << 8) | 7);
    wr(A_MISC, (2 << 25) | 10);

    // little-endian word access
    loadWord(0, 32'h44332211);
    rd(A_BUF, d);   check(d == 32'h44332211, "R1 buffer word readback", d, 32'h44332211);

    // send 4, receive 5
    loadWord(0, 32'h00102003);
    startXfer(4, 5);
    rd(A_CTRL, d);  check(d[1:0] == 2'b11, "R2 ready and wip after trigger", d, 32'h0B);
    check(!spiCsN, "R2 chip select low", spiCsN, 0);
    waitIdle();
    rd(A_CTRL, d);  check(d[1:0] == 2'b10, "R2 ready held, wip clear", d, 32'h0A);
    check(sckRises == 72, "R7 pulse count 9 bytes", sckRises, 72);
    check(expMosi.size() == 0, "R5 all send bytes seen", expMosi.size(), 0);
    rd(A_BUF + 4, d);
    check(d == {resp(7), resp(6), resp(5), resp(4)}, "R6 received bytes 4..7", d, {resp(7), resp(6), resp(5), resp(4)});
    rd(A_BUF + 8, d); check(d[7:0] == resp(8), "R6 received byte 8", d[7:0], resp(8));
    rd(A_BUF, d);   check(d == 32'h00102003, "R6 send bytes kept", d, 32'h00102003);
    for (int i = 4; i < 9; i++) img[i] = resp(i);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, d);  check(d[1] == 1'b0, "R2 ready cleared by idle write", d, 0);

    // send only
    loadWord(0, 32'h0302019F);
    loadWord(1, 32'hDDEE0504);
    startXfer(6, 0);
    waitIdle();
    check(sckRises == 48, "R7 send-only pulse count", sckRises, 48);
    rd(A_BUF + 4, d); check(d == 32'hDDEE0504, "R7 buffer untouched with no receive", d, 32'hDDEE0504);

    // trigger and writes while busy
    startXfer(2, 10);
    repeat (20) @(negedge clk);
    wr(A_IN, 32'd50);
    wr(A_CTRL, 32'h0C);
    wr(A_BUF + 40, 32'hFFFFFFFF);
    waitIdle();
    check(sckRises == 96, "R3 busy trigger ignored", sckRises, 96);
    rd(A_IN, d);      check(d == 10, "R11 count write ignored while busy", d, 10);
    rd(A_BUF + 40, d); check(d == 32'h0, "R11 buffer write ignored while busy", d, 0);
    for (int i = 2; i < 12; i++) img[i] = resp(i);
    repeat (30) @(negedge clk);
    check(spiCsN && sckRises == 96, "R3 no extra transaction", sckRises, 96);
    wr(A_CTRL, 32'h0);

    // illegal totals
    lows = 0;
    wr(A_OUT, 32'd100); wr(A_IN, 32'd40); wr(A_CTRL, 32'h0C);
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (!spiCsN) lows++; end
    rd(A_CTRL, d);    check(lows == 0 && d[1:0] == 2'b00, "R4 total 140 ignored", d, 32'h08);
    wr(A_OUT, 32'd0); wr(A_IN, 32'd0); wr(A_CTRL, 32'h0C);
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (!spiCsN) lows++; end
    rd(A_CTRL, d);    check(lows == 0 && d[1:0] == 2'b00, "R4 total 0 ignored", d, 32'h08);

    // deselect guard
    wr(A_MISC, (2 << 25) | 20);
    startXfer(1, 1);
    @(posedge spiCsN);
    repeat (14) @(negedge clk);
    rd(A_CTRL, d);    check(d[0] == 1'b1, "R8 wip held during deselect time", d, 32'h0B);
    waitIdle();
    img[1] = resp(1);
    wr(A_MISC, (2 << 25) | 10);

    // software reset mid-transfer
    startXfer(1, 20);
    repeat (30) @(negedge clk);
    wr(A_MISC, (1 << 28) | (2 << 25) | 10);
    check(spiCsN && !spiSck, "R9 pins idle after reset", {spiCsN, spiSck}, 2'b10);
    rd(A_STAT, d);    check(d[3:0] == 4'd0, "R9 status idle", d, 0);
    rd(A_CTRL, d);    check(d[1:0] == 2'b00, "R9 flags cleared", d, 32'h08);
    rd(A_MISC, d);    check(d == ((2 << 25) | 10), "R9 reset bit reads 0", d, (2 << 25) | 10);
    expMosi.delete();

    // full buffer: send 1, receive 127
    startXfer(1, 127);
    waitIdle();
    check(sckRises == 1024, "R4 total 128 accepted", sckRises, 1024);
    rd(A_BUF + 124, d); check(d[31:24] == resp(127), "R6 last buffer byte", d[31:24], resp(127));
    rd(A_BUF, d);     check(d[15:0] == {resp(1), img[0]}, "R6 first received byte", d[15:0], {resp(1), img[0]});

    finish();
  end

endmodule